// File: doc/BRIEF.md
# Banked Byte-Write Register File

This block is the write side of the control registers in a small network controller. It takes a byte write strobe, a byte address and a data byte. Only a 4-bit offset is decoded, so the block sees a window of 16 byte locations. One location holds a bank number. The bank number chooses which register set the other offsets reach. The block holds several 16-bit registers and presents their values on output ports for the rest of the controller to read.

Each 16-bit register is written one byte at a time. A write to the low-half offset or the high-half offset replaces only that byte. The receive control register has a reset bit in its top bit. When a write to its upper byte leaves that bit set, the block returns every register to its reset value and raises a one-cycle reset pulse that the rest of the controller can use. Writes to offsets that are reserved or not defined for the current bank are accepted and have no effect.

Top module: `regif_bank_regs`

## Requirements
- R1: Only the low 4 bits of `wr_addr` select a location. For example, address 0x3E acts like offset 14, and address 0x10 acts like offset 0.
- R2: A write to offset 14 loads `bank_o` with `wr_data`, whatever the current bank. A write to offset 15 changes nothing.
- R3: In bank 0, offset 0 writes `tx_ctrl_o[7:0]`, offset 1 writes `tx_ctrl_o[15:8]`, offset 4 writes `rx_ctrl_o[7:0]` and offset 5 writes `rx_ctrl_o[15:8]`. Each value is visible on the clock edge that samples the write.
- R4: A write at bank 0, offset 5 whose data bit 7 is 1 sets `rx_ctrl_o` bit 15. After that clock edge, every register holds its reset value.
- R5: `soft_rst_o` is high for exactly one cycle, in the cycle after the triggering write edge. It is low at all other times.
- R6: In bank 1, offset 0 writes `cfg_o[7:0]` and offset 1 writes `cfg_o[15:8]`.
- R7: After reset the outputs hold these values:

  | Output | Reset value |
  |---|---|
  | `bank_o` | 0x00 |
  | `tx_ctrl_o` | 0x0000 |
  | `rx_ctrl_o` | 0x0000 |
  | `cfg_o` | 0xA0B1 |
  | `ctl_o` | 0x1210 |
  | `ptr_o` | 0x0000 |
  | `erx_o` | 0x001F |
  | `soft_rst_o` | 0 |

- R8: A byte write to one half of a register leaves the other half unchanged.
- R9: The following writes change no output:
  - writes to offsets 10 to 13 in bank 0;
  - writes to any offset not listed for the selected bank;
  - writes in any bank other than 0 or 1, except at offset 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 8 | Byte address; only the low 4 bits are decoded |
| wr_data | input | 8 | Write data byte |
| bank_o | output | 8 | Current bank number |
| tx_ctrl_o | output | 16 | Transmit control register |
| rx_ctrl_o | output | 16 | Receive control register |
| cfg_o | output | 16 | Configuration register |
| ctl_o | output | 16 | Control register |
| ptr_o | output | 16 | Pointer register |
| erx_o | output | 16 | Early-receive register |
| soft_rst_o | output | 1 | One-cycle soft-reset pulse |

## Verification
The bench builds the block with its default parameters: an 8-bit address, a 4-bit offset and byte data. With these values, addresses whose upper nibble is not zero check that offset decoding wraps. Bank numbers 0, 1 and 2 reach both defined register sets and an undefined one. A write sequence that carries state from step to step checks that each half-write keeps the other byte. Directed steps then trigger the soft reset from a state where every register has been changed, and confirm the pulse width.

// File: rtl/regif_pkg.sv
package regif_pkg;

    localparam int DATA_W = 8;
    localparam int REG_W  = 2 * DATA_W;
    localparam int OFF_W  = 4;

    // Offsets decoded in the 16-location window.
    localparam logic [OFF_W-1:0] OFF_BANK  = 4'd14;
    localparam logic [OFF_W-1:0] OFF_NONE  = 4'd15;
    localparam logic [OFF_W-1:0] OFF_TX_LO = 4'd0;
    localparam logic [OFF_W-1:0] OFF_TX_HI = 4'd1;
    localparam logic [OFF_W-1:0] OFF_RX_LO = 4'd4;
    localparam logic [OFF_W-1:0] OFF_RX_HI = 4'd5;
    localparam logic [OFF_W-1:0] OFF_CF_LO = 4'd0;
    localparam logic [OFF_W-1:0] OFF_CF_HI = 4'd1;

    localparam logic [DATA_W-1:0] BANK_MAIN = 8'd0;
    localparam logic [DATA_W-1:0] BANK_CONF = 8'd1;

    // Indices of the byte-writable registers.
    localparam int IDX_TX  = 0;
    localparam int IDX_RX  = 1;
    localparam int IDX_CF  = 2;
    localparam int NUM_RW  = 3;

    localparam logic [REG_W-1:0] RST_TX  = 16'h0000;
    localparam logic [REG_W-1:0] RST_RX  = 16'h0000;
    localparam logic [REG_W-1:0] RST_CF  = 16'hA0B1;
    localparam logic [REG_W-1:0] RST_CTL = 16'h1210;
    localparam logic [REG_W-1:0] RST_PTR = 16'h0000;
    localparam logic [REG_W-1:0] RST_ERX = 16'h001F;

    typedef struct packed {
        logic              bank_we;
        logic [NUM_RW-1:0] lo_we;
        logic [NUM_RW-1:0] hi_we;
    } wstb_t;

    typedef struct packed {
        logic [DATA_W-1:0] bank;
        logic [REG_W-1:0]  tx;
        logic [REG_W-1:0]  rx;
        logic [REG_W-1:0]  cf;
        logic [REG_W-1:0]  ctl;
        logic [REG_W-1:0]  ptr;
        logic [REG_W-1:0]  erx;
        logic              srst;
    } regs_t;

    localparam regs_t REGS_RESET = '{
        bank: BANK_MAIN,
        tx:   RST_TX,
        rx:   RST_RX,
        cf:   RST_CF,
        ctl:  RST_CTL,
        ptr:  RST_PTR,
        erx:  RST_ERX,
        srst: 1'b0
    };

endpackage

// File: rtl/regif_decode.sv
module regif_decode
    import regif_pkg::*;
#(
    parameter int OW = OFF_W,
    parameter int BW = DATA_W
) (
    input  logic          wr_en,
    input  logic [OW-1:0] off,
    input  logic [BW-1:0] bank,
    output wstb_t         wstb
);

    always_comb begin
        wstb = '0;
        if (wr_en) begin
            if (off == OFF_BANK) begin
                wstb.bank_we = 1'b1;
            end else if (off == OFF_NONE) begin
                wstb = '0;
            end else if (bank == BANK_MAIN) begin
                unique case (off)
                    OFF_TX_LO: wstb.lo_we[IDX_TX] = 1'b1;
                    OFF_TX_HI: wstb.hi_we[IDX_TX] = 1'b1;
                    OFF_RX_LO: wstb.lo_we[IDX_RX] = 1'b1;
                    OFF_RX_HI: wstb.hi_we[IDX_RX] = 1'b1;
                    // 10..13 reserved; the rest unlisted: dropped
                    default:   wstb = '0;
                endcase
            end else if (bank == BANK_CONF) begin
                unique case (off)
                    OFF_CF_LO: wstb.lo_we[IDX_CF] = 1'b1;
                    OFF_CF_HI: wstb.hi_we[IDX_CF] = 1'b1;
                    default:   wstb = '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/regif_half_merge.sv
module regif_half_merge
    import regif_pkg::*;
#(
    parameter int DW = DATA_W,
    localparam int RW = 2 * DW
) (
    input  logic [RW-1:0] cur,
    input  logic [DW-1:0] data,
    input  logic          we_lo,
    input  logic          we_hi,
    output logic [RW-1:0] nxt
);

    always_comb begin
        nxt = cur;
        if (we_lo) nxt[DW-1:0]  = data;
        if (we_hi) nxt[RW-1:DW] = data;
    end

endmodule

// File: rtl/regif_bank_regs.sv
module regif_bank_regs
    import regif_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DW     = DATA_W,
    parameter int OW     = OFF_W,
    localparam int RW    = 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] bank_o,
    output logic [RW-1:0] tx_ctrl_o,
    output logic [RW-1:0] rx_ctrl_o,
    output logic [RW-1:0] cfg_o,
    output logic [RW-1:0] ctl_o,
    output logic [RW-1:0] ptr_o,
    output logic [RW-1:0] erx_o,
    output logic          soft_rst_o
);

    regs_t r_q, r_d;
    wstb_t wstb;

    logic [OW-1:0]            off;
    logic [NUM_RW-1:0][RW-1:0] cur_w;
    logic [NUM_RW-1:0][RW-1:0] mrg_w;

    assign off = wr_addr[OW-1:0];

    regif_decode #(.OW(OW), .BW(DW)) u_decode (
        .wr_en (wr_en),
        .off   (off),
        .bank  (r_q.bank),
        .wstb  (wstb)
    );

    assign cur_w[IDX_TX] = r_q.tx;
    assign cur_w[IDX_RX] = r_q.rx;
    assign cur_w[IDX_CF] = r_q.cf;

    for (genvar i = 0; i < NUM_RW; i++) begin : g_merge
        regif_half_merge #(.DW(DW)) u_merge (
            .cur   (cur_w[i]),
            .data  (wr_data),
            .we_lo (wstb.lo_we[i]),
            .we_hi (wstb.hi_we[i]),
            .nxt   (mrg_w[i])
        );
    end

    always_comb begin
        r_d      = r_q;
        r_d.srst = 1'b0;
        if (wstb.bank_we) r_d.bank = wr_data;
        r_d.tx = mrg_w[IDX_TX];
        r_d.rx = mrg_w[IDX_RX];
        r_d.cf = mrg_w[IDX_CF];
        // Soft reset: upper receive-control byte written with its top bit set
        if (wstb.hi_we[IDX_RX] && mrg_w[IDX_RX][RW-1]) begin
            r_d      = REGS_RESET;
            r_d.srst = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= REGS_RESET;
        else        r_q <= r_d;
    end

    assign bank_o     = r_q.bank;
    assign tx_ctrl_o  = r_q.tx;
    assign rx_ctrl_o  = r_q.rx;
    assign cfg_o      = r_q.cf;
    assign ctl_o      = r_q.ctl;
    assign ptr_o      = r_q.ptr;
    assign erx_o      = r_q.erx;
    assign soft_rst_o = r_q.srst;

endmodule

// File: rtl/regif_bank_regs_chk.sv
module regif_bank_regs_chk #(
    parameter int ADDR_W = 8,
    parameter int DW     = 8,
    localparam int RW    = 2 * DW
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DW-1:0]     wr_data,
    input logic [DW-1:0]     bank_o,
    input logic [RW-1:0]     tx_ctrl_o,
    input logic [RW-1:0]     rx_ctrl_o,
    input logic [RW-1:0]     cfg_o,
    input logic              soft_rst_o
);

    logic [3:0] off;
    assign off = wr_addr[3:0];

    p_bank_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && off == 4'd14) |=> (bank_o == $past(wr_data)));

    p_off15_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && off == 4'd15) |=>
            ($stable(bank_o) && $stable(tx_ctrl_o) && $stable(rx_ctrl_o)
             && $stable(cfg_o) && !soft_rst_o));

    p_tx_lo_keeps_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && off == 4'd0 && bank_o == '0) |=>
            (tx_ctrl_o == {$past(tx_ctrl_o[RW-1:DW]), $past(wr_data)}));

    p_cfg_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && off == 4'd1 && bank_o == 8'd1) |=>
            (cfg_o == {$past(wr_data), $past(cfg_o[DW-1:0])}));

    p_srst_trigger_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && off == 4'd5 && bank_o == '0 && wr_data[DW-1]) |=>
            (soft_rst_o && rx_ctrl_o == '0 && tx_ctrl_o == '0 && bank_o == '0
             && cfg_o == 16'hA0B1));

    p_srst_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_o |=> !soft_rst_o);

    p_reserved_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bank_o == '0 && off >= 4'd10 && off <= 4'd13) |=>
            ($stable(tx_ctrl_o) && $stable(rx_ctrl_o) && $stable(cfg_o)
             && $stable(bank_o)));

endmodule

bind regif_bank_regs regif_bank_regs_chk #(.ADDR_W(ADDR_W), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .bank_o     (bank_o),
    .tx_ctrl_o  (tx_ctrl_o),
    .rx_ctrl_o  (rx_ctrl_o),
    .cfg_o      (cfg_o),
    .soft_rst_o (soft_rst_o)
);

// File: tb/regif_bank_regs_bench.sv
module regif_bank_regs_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  bank_o;
    logic [15:0] tx_ctrl_o, rx_ctrl_o, cfg_o, ctl_o, ptr_o, erx_o;
    logic        soft_rst_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    regif_bank_regs u_regif_bank_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .bank_o(bank_o), .tx_ctrl_o(tx_ctrl_o),
        .rx_ctrl_o(rx_ctrl_o), .cfg_o(cfg_o), .ctl_o(ctl_o), .ptr_o(ptr_o),
        .erx_o(erx_o), .soft_rst_o(soft_rst_o)
    );

    // {addr, data, exp_tx, exp_rx, exp_cfg, exp_bank}
    localparam int NV = 16;
    localparam logic [71:0] VEC [NV] = '{
        {8'h00, 8'h5A, 16'h005A, 16'h0000, 16'hA0B1, 8'h00}, // R3
        {8'h01, 8'h3C, 16'h3C5A, 16'h0000, 16'hA0B1, 8'h00}, // R3 R8
        {8'h04, 8'h11, 16'h3C5A, 16'h0011, 16'hA0B1, 8'h00}, // R3
        {8'h05, 8'h22, 16'h3C5A, 16'h2211, 16'hA0B1, 8'h00}, // R3 R8
        {8'h0A, 8'hFF, 16'h3C5A, 16'h2211, 16'hA0B1, 8'h00}, // R9
        {8'h0D, 8'hFF, 16'h3C5A, 16'h2211, 16'hA0B1, 8'h00}, // R9
        {8'h02, 8'h77, 16'h3C5A, 16'h2211, 16'hA0B1, 8'h00}, // R9
        {8'h0F, 8'h01, 16'h3C5A, 16'h2211, 16'hA0B1, 8'h00}, // R2
        {8'h3E, 8'h01, 16'h3C5A, 16'h2211, 16'hA0B1, 8'h01}, // R1 R2
        {8'h00, 8'h12, 16'h3C5A, 16'h2211, 16'hA012, 8'h01}, // R6 R8
        {8'h01, 8'h34, 16'h3C5A, 16'h2211, 16'h3412, 8'h01}, // R6
        {8'h04, 8'h99, 16'h3C5A, 16'h2211, 16'h3412, 8'h01}, // R9
        {8'hFE, 8'h02, 16'h3C5A, 16'h2211, 16'h3412, 8'h02}, // R1 R2
        {8'h00, 8'h55, 16'h3C5A, 16'h2211, 16'h3412, 8'h02}, // R9
        {8'h0E, 8'h00, 16'h3C5A, 16'h2211, 16'h3412, 8'h00}, // R2
        {8'h10, 8'hA5, 16'h3CA5, 16'h2211, 16'h3412, 8'h00}  // R1
    };

    task automatic chk(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Drive at the falling edge; the write lands on the next rising edge;
    // the result is sampled at the following falling edge.
    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        #400000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R7: reset state
        chk("R7", "bank", {8'h0, bank_o}, 16'h0000);
        chk("R7", "tx",   tx_ctrl_o, 16'h0000);
        chk("R7", "rx",   rx_ctrl_o, 16'h0000);
        chk("R7", "cfg",  cfg_o,     16'hA0B1);
        chk("R7", "ctl",  ctl_o,     16'h1210);
        chk("R7", "ptr",  ptr_o,     16'h0000);
        chk("R7", "erx",  erx_o,     16'h001F);
        chk("R7", "srst", {15'h0, soft_rst_o}, 16'h0000);

        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][71:64], VEC[i][63:56]);
            chk("R3/R8", $sformatf("tx v%0d", i),  tx_ctrl_o, VEC[i][55:40]);
            chk("R3/R8", $sformatf("rx v%0d", i),  rx_ctrl_o, VEC[i][39:24]);
            chk("R6/R9", $sformatf("cfg v%0d", i), cfg_o,     VEC[i][23:8]);
            chk("R1/R2", $sformatf("bank v%0d", i), {8'h0, bank_o}, {8'h0, VEC[i][7:0]});
            chk("R5", $sformatf("no pulse v%0d", i), {15'h0, soft_rst_o}, 16'h0000);
        end

        // R4 / R5: soft reset from a fully modified state
        wr(8'h04, 8'h0F);
        chk("R3", "rx lo before reset", rx_ctrl_o, 16'h220F);
        wr(8'h05, 8'h80);
        chk("R4", "tx after srst",  tx_ctrl_o, 16'h0000);
        chk("R4", "rx after srst",  rx_ctrl_o, 16'h0000);
        chk("R4", "cfg after srst", cfg_o,     16'hA0B1);
        chk("R4", "bank after srst", {8'h0, bank_o}, 16'h0000);
        chk("R4", "erx after srst", erx_o,     16'h001F);
        chk("R5", "pulse high",     {15'h0, soft_rst_o}, 16'h0001);
        @(negedge clk);
        chk("R5", "pulse one cycle", {15'h0, soft_rst_o}, 16'h0000);

        // R4: reset bit through an aliased address, after moving bank away and back
        wr(8'h0E, 8'h01);
        wr(8'h00, 8'hCC);
        chk("R6", "cfg lo", cfg_o, 16'hA0CC);
        wr(8'h5E, 8'h00);
        wr(8'h25, 8'hFF);
        chk("R4", "aliased srst cfg", cfg_o, 16'hA0B1);
        chk("R5", "aliased pulse", {15'h0, soft_rst_o}, 16'h0001);

        // R4: offset 5 in bank 1 does not trigger
        wr(8'h0E, 8'h01);
        wr(8'h05, 8'h80);
        chk("R9", "bank1 off5 no pulse", {15'h0, soft_rst_o}, 16'h0000);
        chk("R9", "bank1 off5 rx", rx_ctrl_o, 16'h0000);
        chk("R9", "bank1 off5 bank", {8'h0, bank_o}, 16'h0001);

        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule